// File: doc/BRIEF.md
# Control Endpoint Setup Lockout

This block holds the command-side state of the control endpoint pair of a full-speed USB device controller. The pair is a control OUT endpoint (index 0) and a control IN endpoint (index 1). A modelled serial engine reports finished transactions as single-cycle events. Each event carries an endpoint index, a SETUP flag, a data PID and an 8-bit transaction error code. The CPU side sends 8-bit command codes, one per cycle, plus an endpoint select bit for the commands that act on one control endpoint.

A SETUP packet on endpoint 0 locks the buffer-validate and buffer-clear commands on both control endpoints. The CPU must send an acknowledge to each endpoint in turn, and each lock releases only on its own acknowledge. If a second SETUP overwrites setup data that is still unacknowledged, the block raises an overwrite flag. A status read clears that flag, but only once the engine has finished writing the new setup data. For every endpoint index the block also stores the error code of the most recent transaction, and the CPU can read it back.

Top module: `ctrl_setup_lock`

## Requirements
- R1: After reset both status images read 0x00, `ep_lock` is 2'b00, and all sixteen error codes read 0x00.
- R2: A SETUP event on endpoint 0 does the following one cycle later. Both `ep_lock` bits become 1. The OUT image shows setup-present=1, primary-full=1, secondary-full=0, PID=0 and CPU select=0.
- R3: Command 0xFA (validate) and command 0xF2 (clear) on a locked endpoint have no effect. The endpoint's image reads back unchanged.
- R4: Command 0xF4 with `cmd_ep` set clears only that endpoint's lock bit. On endpoint 0 it also clears setup-present.
- R5: A SETUP event sets the overwrite bit (image bit 3) only if endpoint 0 is locked and not stalled when the event arrives.
- R6: A status read clears the overwrite bit when `setup_busy` is 0. When `setup_busy` is 1 the bit stays set. The read always returns the value the bit held before the read.
- R7: A SETUP event clears the stall bit on both control endpoints, sets setup-present again, and locks both endpoints again.
- R8: On an unlocked endpoint, 0xFA sets the full flag of the CPU-selected buffer and 0xF2 clears it. Each of these commands then toggles CPU select (image bit 1, 0 = primary).
- R9: A data event with error code 0 works on the engine-side buffer pointer, which starts at primary and toggles on each such event. On endpoint 0 the event sets that buffer's full flag. On endpoint 1 it clears that buffer's full flag. Either way, image bit 4 takes the event's PID. A data event with a nonzero code leaves the image unchanged.
- R10: Codes 0xA0 to 0xAF read the stored error code of endpoint index 0 to 15. Every event overwrites the stored code of its own index.
- R11: Codes 0xD0 and 0xD1 read the OUT and IN images. The image layout is: bit7 stall, bit6 secondary full, bit5 primary full, bit4 PID, bit3 overwrite, bit2 setup present, bit1 CPU select, bit0 always 0. For any read, `rd_valid` pulses with the data exactly one cycle after the command.
- R12: If a SETUP event and an acknowledge arrive in the same cycle, the SETUP wins and the lock stays set. Codes that are not defined change nothing.
- R13: Command 0x43 stalls the selected endpoint and command 0x42 unstalls it. Neither command is blocked by the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Transaction event strobe from the serial engine |
| ev_setup | input | 1 | Event is a SETUP packet |
| ev_ep | input | 4 | Endpoint index of the event |
| ev_pid | input | 1 | Data PID of the event (0 = DATA0) |
| ev_err | input | 8 | Error code of the event, 0 = good |
| setup_busy | input | 1 | Engine still writing setup data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cmd_ep | input | 1 | Control endpoint select (0 = OUT, 1 = IN) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Status image or error code |
| ep_lock | output | 2 | Lock state, bit 0 = OUT, bit 1 = IN |

## Verification
The lock is tested in four situations: a single SETUP, a SETUP while the endpoint is already locked, a SETUP while the endpoint is stalled, and a SETUP in the same cycle as an acknowledge. Comparing these separates the overwrite condition from the stall and priority rules. Acknowledges are sent one endpoint at a time, which shows that each lock bit releases independently. Validate and clear commands are sent both while locked and while unlocked, and runs of data events alternate between buffers. Together these separate the CPU select pointer from the engine-side pointer. Status reads with `setup_busy` high and then low show that the overwrite clear depends on the write having finished.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam logic [7:0] CMD_ACK      = 8'hF4;
  localparam logic [7:0] CMD_VALIDATE = 8'hFA;
  localparam logic [7:0] CMD_CLEAR    = 8'hF2;
  localparam logic [7:0] CMD_STALL    = 8'h43;
  localparam logic [7:0] CMD_UNSTALL  = 8'h42;
  localparam logic [6:0] CMD_STAT_HI  = 7'h68;  // 0xD0 / 0xD1
  localparam logic [3:0] CMD_ERR_HI   = 4'hA;   // 0xA0 .. 0xAF

  typedef struct packed {
    logic ack;
    logic val;
    logic clr;
    logic stall_set;
    logic stall_clr;
    logic stat_rd;
  } ep_cmd_t;
endpackage

// File: rtl/csl_cmd_dec.sv
module csl_cmd_dec
  import csl_pkg::*;
#(
  parameter int EP_W = 4
) (
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_code,
  input  logic            cmd_ep,
  output ep_cmd_t         out_cmd,
  output ep_cmd_t         in_cmd,
  output logic            err_rd,
  output logic [EP_W-1:0] err_idx,
  output logic            stat_rd,
  output logic            stat_sel
);
  logic ack, val, clr, st_set, st_clr;

  always_comb begin
    ack      = cmd_valid && (cmd_code == CMD_ACK);
    val      = cmd_valid && (cmd_code == CMD_VALIDATE);
    clr      = cmd_valid && (cmd_code == CMD_CLEAR);
    st_set   = cmd_valid && (cmd_code == CMD_STALL);
    st_clr   = cmd_valid && (cmd_code == CMD_UNSTALL);
    stat_rd  = cmd_valid && (cmd_code[7:1] == CMD_STAT_HI);
    stat_sel = cmd_code[0];
    err_rd   = cmd_valid && (cmd_code[7:4] == CMD_ERR_HI);
    err_idx  = EP_W'(cmd_code[3:0]);

    out_cmd.ack       = ack    && !cmd_ep;
    out_cmd.val       = val    && !cmd_ep;
    out_cmd.clr       = clr    && !cmd_ep;
    out_cmd.stall_set = st_set && !cmd_ep;
    out_cmd.stall_clr = st_clr && !cmd_ep;
    out_cmd.stat_rd   = stat_rd && !stat_sel;

    in_cmd.ack        = ack    && cmd_ep;
    in_cmd.val        = val    && cmd_ep;
    in_cmd.clr        = clr    && cmd_ep;
    in_cmd.stall_set  = st_set && cmd_ep;
    in_cmd.stall_clr  = st_clr && cmd_ep;
    in_cmd.stat_rd    = stat_rd && stat_sel;
  end
endmodule

// File: rtl/csl_ctrl_ep.sv
module csl_ctrl_ep
  import csl_pkg::*;
#(
  parameter bit IS_OUT = 1'b1,  // endpoint that receives SETUP data
  parameter bit DBL    = 1'b1   // two buffers
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       setup_in,
  input  logic       data_in,
  input  logic       data_pid,
  input  ep_cmd_t    cmd,
  input  logic       wr_busy,
  output logic [7:0] img,
  output logic       locked
);
  logic       stall_q, pid_q, ovr_q, setupt_q, sel_q, hw_q, lock_q;
  logic [1:0] full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q  <= 1'b0;
      full_q   <= 2'b00;
      pid_q    <= 1'b0;
      ovr_q    <= 1'b0;
      setupt_q <= 1'b0;
      sel_q    <= 1'b0;
      hw_q     <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      if (cmd.stall_set) stall_q <= 1'b1;
      if (cmd.stall_clr) stall_q <= 1'b0;
      if (cmd.ack) begin
        lock_q <= 1'b0;
        if (IS_OUT) setupt_q <= 1'b0;
      end
      // buffer commands only pass when unlocked
      if (!lock_q && cmd.val) begin
        full_q[sel_q] <= 1'b1;
        if (DBL) sel_q <= ~sel_q;
      end
      if (!lock_q && cmd.clr) begin
        full_q[sel_q] <= 1'b0;
        if (DBL) sel_q <= ~sel_q;
      end
      // engine side: OUT fills, IN drains
      if (data_in) begin
        full_q[hw_q] <= IS_OUT;
        pid_q        <= data_pid;
        if (DBL) hw_q <= ~hw_q;
      end
      if (cmd.stat_rd && !wr_busy) ovr_q <= 1'b0;
      // SETUP has the last word
      if (setup_in) begin
        lock_q  <= 1'b1;
        stall_q <= 1'b0;
        if (IS_OUT) begin
          if (lock_q && !stall_q) ovr_q <= 1'b1;
          setupt_q <= 1'b1;
          full_q   <= 2'b01;
          sel_q    <= 1'b0;
          hw_q     <= DBL;
          pid_q    <= 1'b0;
        end
      end
    end
  end

  assign img    = {stall_q, full_q[1], full_q[0], pid_q, ovr_q, setupt_q, sel_q, 1'b0};
  assign locked = lock_q;
endmodule

// File: rtl/csl_err_store.sv
module csl_err_store #(
  parameter int N_EP  = 16,
  parameter int ERR_W = 8,
  localparam int EP_W = $clog2(N_EP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [EP_W-1:0]  wa,
  input  logic [ERR_W-1:0] wd,
  input  logic [EP_W-1:0]  ra,
  output logic [ERR_W-1:0] rd
);
  logic [ERR_W-1:0] mem [N_EP];
  logic [N_EP-1:0]  vld_q;
  logic [ERR_W-1:0] mem_q;
  logic             vld_rd_q;

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    mem_q <= mem[ra];
  end

  // per-entry written flags give the zero-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      vld_rd_q <= 1'b0;
    end else begin
      if (we) vld_q[wa] <= 1'b1;
      vld_rd_q <= vld_q[ra];
    end
  end

  assign rd = vld_rd_q ? mem_q : '0;
endmodule

// File: rtl/ctrl_setup_lock.sv
module ctrl_setup_lock
  import csl_pkg::*;
#(
  parameter int N_EP     = 16,   // endpoint indices, at most 16
  parameter int ERR_W    = 8,
  parameter bit CTRL_DBL = 1'b1,
  localparam int EP_W    = $clog2(N_EP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic             ev_setup,
  input  logic [EP_W-1:0]  ev_ep,
  input  logic             ev_pid,
  input  logic [ERR_W-1:0] ev_err,
  input  logic             setup_busy,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic             cmd_ep,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic [1:0]       ep_lock
);
  ep_cmd_t         cmds [2];
  logic            err_rd, stat_rd, stat_sel;
  logic [EP_W-1:0] err_idx;
  logic            setup_hit;
  logic [1:0]      data_hit;
  logic [7:0]      img [2];
  logic [ERR_W-1:0] err_q;
  logic [7:0]      stat_q;
  logic            rd_v_q, rd_err_q;

  csl_cmd_dec #(.EP_W(EP_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_ep    (cmd_ep),
    .out_cmd   (cmds[0]),
    .in_cmd    (cmds[1]),
    .err_rd    (err_rd),
    .err_idx   (err_idx),
    .stat_rd   (stat_rd),
    .stat_sel  (stat_sel)
  );

  assign setup_hit = ev_valid && ev_setup && (ev_ep == '0);

  for (genvar e = 0; e < 2; e++) begin : g_ep
    assign data_hit[e] = ev_valid && !ev_setup && (ev_ep == EP_W'(e)) && (ev_err == '0);
    csl_ctrl_ep #(.IS_OUT(e == 0), .DBL(CTRL_DBL)) u_ep (
      .clk      (clk),
      .rst      (rst),
      .setup_in (setup_hit),
      .data_in  (data_hit[e]),
      .data_pid (ev_pid),
      .cmd      (cmds[e]),
      .wr_busy  (setup_busy),
      .img      (img[e]),
      .locked   (ep_lock[e])
    );
  end

  csl_err_store #(.N_EP(N_EP), .ERR_W(ERR_W)) u_err (
    .clk (clk),
    .rst (rst),
    .we  (ev_valid),
    .wa  (ev_ep),
    .wd  (ev_err),
    .ra  (err_idx),
    .rd  (err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= 8'h00;
      rd_v_q   <= 1'b0;
      rd_err_q <= 1'b0;
    end else begin
      rd_v_q   <= stat_rd || err_rd;
      rd_err_q <= err_rd;
      if (stat_rd) stat_q <= img[stat_sel];
    end
  end

  assign rd_valid = rd_v_q;
  assign rd_data  = !rd_v_q ? 8'h00 : (rd_err_q ? 8'(err_q) : stat_q);
endmodule

// File: rtl/csl_chk.sv
module csl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_valid,
  input logic       ev_setup,
  input logic [3:0] ev_ep,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       cmd_ep,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [1:0] ep_lock
);
  logic setup_c, ack0_c, ack1_c, rd_c, st_c, st_q;

  assign setup_c = ev_valid && ev_setup && (ev_ep == 4'd0);
  assign ack0_c  = cmd_valid && (cmd_code == 8'hF4) && !cmd_ep;
  assign ack1_c  = cmd_valid && (cmd_code == 8'hF4) && cmd_ep;
  assign st_c    = cmd_valid && (cmd_code[7:1] == 7'h68);
  assign rd_c    = st_c || (cmd_valid && (cmd_code[7:4] == 4'hA));

  always_ff @(posedge clk) begin
    if (rst) st_q <= 1'b0;
    else     st_q <= st_c;
  end

  p_setup_locks_r2: assert property (@(posedge clk) disable iff (rst)
    setup_c |=> (ep_lock == 2'b11));
  p_lock_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ep_lock[1]) |-> $past(setup_c));
  p_ack_out_r4: assert property (@(posedge clk) disable iff (rst)
    (ack0_c && !setup_c) |=> !ep_lock[0]);
  p_ack_in_r4: assert property (@(posedge clk) disable iff (rst)
    (ack1_c && !setup_c) |=> !ep_lock[1]);
  p_lock_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ep_lock[0]) |-> $past(ack0_c));
  p_setup_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (setup_c && ack0_c) |=> ep_lock[0]);
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    rd_c |=> rd_valid);
  p_no_spurious_rd_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_c |=> !rd_valid);
  p_bit0_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q && rd_valid) |-> !rd_data[0]);
endmodule

bind ctrl_setup_lock csl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_setup  (ev_setup),
  .ev_ep     (ev_ep),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_ep    (cmd_ep),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .ep_lock   (ep_lock)
);

// File: tb/ctrl_setup_lock_test.sv
module ctrl_setup_lock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 0, ev_setup = 0, ev_pid = 0;
  logic [3:0] ev_ep = 0;
  logic [7:0] ev_err = 0;
  logic       setup_busy = 0;
  logic       cmd_valid = 0, cmd_ep = 0;
  logic [7:0] cmd_code = 0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [1:0] ep_lock;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  bit         m_stall[2], m_pid[2], m_ovr[2], m_stp[2], m_sel[2], m_hw[2], m_lock[2];
  logic [1:0] m_full[2];
  logic [7:0] m_err[16];

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  ctrl_setup_lock uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_setup(ev_setup), .ev_ep(ev_ep),
    .ev_pid(ev_pid), .ev_err(ev_err), .setup_busy(setup_busy), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_ep(cmd_ep), .rd_valid(rd_valid), .rd_data(rd_data),
    .ep_lock(ep_lock)
  );

  function automatic logic [7:0] m_img(int e);
    return {m_stall[e], m_full[e][1], m_full[e][0], m_pid[e], m_ovr[e], m_stp[e], m_sel[e], 1'b0};
  endfunction

  task automatic m_setup();
    if (m_lock[0] && !m_stall[0]) m_ovr[0] = 1;
    m_lock[0] = 1; m_lock[1] = 1;
    m_stall[0] = 0; m_stall[1] = 0;
    m_stp[0] = 1; m_full[0] = 2'b01; m_sel[0] = 0; m_hw[0] = 1; m_pid[0] = 0;
  endtask

  task automatic m_cmd(logic [7:0] code, bit ep, string tag);
    if (code == 8'hF4) begin
      m_lock[ep] = 0; if (ep == 0) m_stp[0] = 0;
    end else if (code == 8'hFA && !m_lock[ep]) begin
      m_full[ep][m_sel[ep]] = 1; m_sel[ep] = ~m_sel[ep];
    end else if (code == 8'hF2 && !m_lock[ep]) begin
      m_full[ep][m_sel[ep]] = 0; m_sel[ep] = ~m_sel[ep];
    end else if (code == 8'h43) m_stall[ep] = 1;
    else if (code == 8'h42) m_stall[ep] = 0;
    else if (code[7:1] == 7'h68) begin
      q_exp.push_back(m_img(code[0])); q_tag.push_back(tag);
      if (!setup_busy) m_ovr[code[0]] = 0;
    end else if (code[7:4] == 4'hA) begin
      q_exp.push_back(m_err[code[3:0]]); q_tag.push_back(tag);
    end
  endtask

  // driver: one command in one cycle
  task automatic do_cmd(logic [7:0] code, bit ep, string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_ep = ep;
    m_cmd(code, ep, tag);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_ev(bit stp, int ep, bit pid, logic [7:0] err);
    @(negedge clk);
    ev_valid = 1; ev_setup = stp; ev_ep = 4'(ep); ev_pid = pid; ev_err = err;
    m_err[ep] = err;
    if (stp && ep == 0) m_setup();
    else if (!stp && ep < 2 && err == 0) begin
      m_full[ep][m_hw[ep]] = (ep == 0);
      m_pid[ep] = pid; m_hw[ep] = ~m_hw[ep];
    end
    @(negedge clk);
    ev_valid = 0; ev_setup = 0;
  endtask

  task automatic do_setup_and_ack(bit ep);
    @(negedge clk);
    ev_valid = 1; ev_setup = 1; ev_ep = 0; ev_err = 0; m_err[0] = 0;
    cmd_valid = 1; cmd_code = 8'hF4; cmd_ep = ep;
    m_cmd(8'hF4, ep, "R12");
    m_setup();
    @(negedge clk);
    ev_valid = 0; ev_setup = 0; cmd_valid = 0;
  endtask

  task automatic chk_lock(string tag);
    logic [1:0] exp;
    exp = {m_lock[1], m_lock[0]};
    checks++;
    if (ep_lock !== exp) begin
      failures++;
      $display("FAIL %s ep_lock actual=%b expected=%b", tag, ep_lock, exp);
    end
  endtask

  task automatic rd_both(string tag);
    do_cmd(8'hD0, 0, tag);
    do_cmd(8'hD1, 0, tag);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected read actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_err[i] = 0;
    for (int e = 0; e < 2; e++) begin
      m_stall[e] = 0; m_pid[e] = 0; m_ovr[e] = 0; m_stp[e] = 0;
      m_sel[e] = 0; m_hw[e] = 0; m_lock[e] = 0; m_full[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk_lock("R1");
    rd_both("R1");
    for (int i = 0; i < 16; i++) do_cmd(8'hA0 + 8'(i), 0, "R1");

    // R8 unlocked validate / clear, alternating buffers
    do_cmd(8'hFA, 1, "R8");
    rd_both("R8");
    do_cmd(8'hFA, 1, "R8");
    do_cmd(8'hD1, 0, "R8");
    do_cmd(8'hF2, 1, "R8");
    do_cmd(8'hD1, 0, "R8");

    // R9 data events: IN drains, OUT fills, PID follows, errored ignored
    do_ev(0, 1, 1, 8'h00);
    do_cmd(8'hD1, 0, "R9");
    do_ev(0, 0, 1, 8'h00);
    do_cmd(8'hD0, 0, "R9");
    do_ev(0, 0, 0, 8'h05);
    do_cmd(8'hD0, 0, "R9");
    do_ev(0, 0, 0, 8'h00);
    do_cmd(8'hD0, 0, "R9");

    // R10 error codes, overwrite per index
    do_ev(0, 5, 0, 8'h17);
    do_ev(0, 15, 1, 8'hC3);
    do_cmd(8'hA5, 0, "R10");
    do_cmd(8'hAF, 0, "R10");
    do_cmd(8'hA0, 0, "R10");
    do_ev(0, 5, 0, 8'h2B);
    do_cmd(8'hA5, 0, "R10");

    // R2 first SETUP
    do_ev(1, 0, 0, 8'h00);
    chk_lock("R2");
    rd_both("R2");

    // R3 locked buffer commands ignored
    do_cmd(8'hFA, 1, "R3");
    do_cmd(8'hF2, 0, "R3");
    rd_both("R3");

    // R5/R6 overwrite with busy write, then clear on read
    setup_busy = 1;
    do_ev(1, 0, 0, 8'h00);
    do_cmd(8'hD0, 0, "R5");
    do_cmd(8'hD0, 0, "R6");
    setup_busy = 0;
    do_cmd(8'hD0, 0, "R6");
    do_cmd(8'hD0, 0, "R6");

    // R4 separate acknowledges
    do_cmd(8'hF4, 0, "R4");
    chk_lock("R4");
    do_cmd(8'hD0, 0, "R4");
    do_cmd(8'hF4, 1, "R4");
    chk_lock("R4");
    do_cmd(8'hFA, 0, "R4");
    do_cmd(8'hD0, 0, "R4");

    // R13 stall commands, R7 SETUP clears stall
    do_cmd(8'h43, 0, "R13");
    do_cmd(8'h43, 1, "R13");
    rd_both("R13");
    do_ev(1, 0, 0, 8'h00);
    chk_lock("R7");
    rd_both("R7");
    // R5 stalled while locked: no overwrite
    do_cmd(8'h43, 0, "R5");
    do_ev(1, 0, 0, 8'h00);
    do_cmd(8'hD0, 0, "R5");
    do_cmd(8'h42, 1, "R13");
    do_cmd(8'h43, 1, "R13");
    do_cmd(8'h42, 1, "R13");
    do_cmd(8'hD1, 0, "R13");

    // R12 SETUP beats same-cycle ack; unknown code no effect
    do_cmd(8'hF4, 0, "R12");
    do_cmd(8'hF4, 1, "R12");
    chk_lock("R12");
    do_setup_and_ack(0);
    chk_lock("R12");
    do_cmd(8'h55, 1, "R12");
    do_cmd(8'hF5, 0, "R12");
    chk_lock("R12");
    rd_both("R12");

    repeat (3) @(negedge clk);
    checks++;
    if (q_exp.size() != 0) begin
      failures++;
      $display("FAIL R11 missing reads actual=%0d expected=0", q_exp.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule